// File: doc/BRIEF.md
# Word-Interleaved Banked Scratchpad Interconnect

This block connects a set of processor request ports to a shared scratchpad built from several single-port memory banks. Successive word addresses land in successive banks, so that streaming accesses from many ports spread evenly and rarely collide. Every port issues at most one word access per cycle. The grant comes back in the same cycle. A port that is not granted keeps its request up and tries again on the next cycle.

Inside the block, each port's bank index passes through a binary tree of 1-to-2 steering stages. That tree raises exactly one request line toward the target bank. Each bank has a binary tree of 2-to-1 round-robin nodes that picks one contender per cycle. The winner's access reaches the bank, and its result returns to the winning port a fixed two cycles after the grant. Accesses to different banks never interact. A clash shows up only as a low grant on the ports that lost.

The bank count is the port count times a banking factor (default 2). Addresses are word addresses; the processor has already removed the byte offset.

Top module: `ilv_xbar`

## Requirements
- R1: The bank of a request is the low BANK_W bits of its word address, and the row inside the bank is the next ROW_W bits above them. Two words contend only when those low bits match.
- R2: `gnt[p]` is never high unless `req[p]` is high. A request that is the only one aimed at its bank in a cycle is granted in that same cycle.
- R3: Requests from several ports to pairwise different banks are all granted in the same cycle.
- R4: In every cycle, each bank grants exactly one of the ports requesting it and no other port, whatever mix of reads and writes is offered.
- R5: Every grant on port p raises `r_valid[p]` for exactly one cycle, two rising clock edges after the grant cycle. `r_valid[p]` is never high at any other time.
- R6: A read returns the word last written at that address. A write changes only the byte lanes whose `be` bit is set, where `be` bit i covers data bits 8i+7 down to 8i.
- R7: When all N ports keep requesting the same bank, each port is granted exactly twice in 2N consecutive cycles, and no port is stalled for N or more consecutive cycles.
- R8: A stalled request that is held is served later with the same effect it would have had without contention; it is never dropped. A read and a write to the same bank in one cycle take effect in grant order.
- R9: A granted write also produces a response, and its `r_data` is the content the word held just before the write.
- R10: With no request, `gnt` is low. `r_valid` is low while reset is high and in the first cycle after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | N_PORTS | Per-port access request |
| addr | input | N_PORTS*ADDR_W | Per-port word address, port p in slice p |
| we | input | N_PORTS | Per-port write select (1 = write, 0 = read) |
| be | input | N_PORTS*4 | Per-port byte lane enables for writes |
| wdata | input | N_PORTS*32 | Per-port write data |
| gnt | output | N_PORTS | Same-cycle grant; low means stall and retry |
| r_valid | output | N_PORTS | Response strobe, two edges after grant |
| r_data | output | N_PORTS*32 | Response data (read word, or prior word on writes) |

## Verification
Two things can happen in the same cycle and collide at a bank: a read and a write from different ports aimed at the same bank, possibly the same word, and grants on unrelated banks. Directed scenarios set up both cases on purpose. A write and a read target one word in one cycle. Three ports pile onto one bank while a fourth uses a free bank. The bench keeps its own memory model and updates it in the order in which grants are seen. Each response is then judged against what that order implies, and it checks that the lone requester on the free bank is still granted in the cycle of the pile-up.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  localparam int WORD_W = 32;
  localparam int BYTES  = WORD_W / 8;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/ilv_route.sv
// Steers one port's request to its bank through BANK_W levels of 1:2 splits.
module ilv_route #(
  parameter  int N_BANKS = 8,
  localparam int BANK_W  = $clog2(N_BANKS)
) (
  input  logic               req,
  input  logic [BANK_W-1:0]  bank,
  output logic [N_BANKS-1:0] hit
);
  // heap layout: node 1 is the root, nodes N_BANKS..2*N_BANKS-1 are banks
  logic [2*N_BANKS-1:1] node;

  assign node[1] = req;

  for (genvar i = 1; i < N_BANKS; i++) begin : g_split
    localparam int LVL = $clog2(i + 1) - 1;
    localparam int SEL = BANK_W - 1 - LVL;
    assign node[2*i]   = node[i] & ~bank[SEL];
    assign node[2*i+1] = node[i] &  bank[SEL];
  end

  for (genvar b = 0; b < N_BANKS; b++) begin : g_leaf
    assign hit[b] = node[N_BANKS + b];
  end
endmodule

// File: rtl/ilv_arb_tree.sv
// Per-bank binary tree of round-robin 2:1 nodes.
module ilv_arb_tree #(
  parameter  int N_PORTS = 4,
  localparam int PORT_W  = $clog2(N_PORTS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_PORTS-1:0] req,
  output logic [N_PORTS-1:0] gnt,
  output logic               valid,
  output logic [PORT_W-1:0]  win
);
  localparam int NODES = 2 * N_PORTS;

  logic [NODES-1:1]   h_req;
  logic [NODES-1:1]   h_gnt;
  logic [PORT_W-1:0]  h_idx [NODES-1:1];
  logic [N_PORTS-1:1] h_right;

  for (genvar p = 0; p < N_PORTS; p++) begin : g_leaf
    assign h_req[N_PORTS + p] = req[p];
    assign h_idx[N_PORTS + p] = PORT_W'(p);
    assign gnt[p]             = h_gnt[N_PORTS + p];
  end

  for (genvar i = 1; i < N_PORTS; i++) begin : g_node
    logic rr_q;  // 1: right child preferred on a tie

    assign h_right[i]   = h_req[2*i+1] & (~h_req[2*i] | rr_q);
    assign h_req[i]     = h_req[2*i] | h_req[2*i+1];
    assign h_idx[i]     = h_right[i] ? h_idx[2*i+1] : h_idx[2*i];
    assign h_gnt[2*i]   = h_gnt[i] & ~h_right[i] & h_req[2*i];
    assign h_gnt[2*i+1] = h_gnt[i] &  h_right[i];

    always_ff @(posedge clk) begin
      if (rst) begin
        rr_q <= 1'b0;
      end else if (h_gnt[i] && h_req[2*i] && h_req[2*i+1]) begin
        rr_q <= ~h_right[i];
      end
    end
  end

  assign h_gnt[1] = h_req[1];
  assign valid    = h_req[1];
  assign win      = h_idx[1];
endmodule

// File: rtl/ilv_bank.sv
// Single-port bank, read-first, byte-lane writes, registered read port.
module ilv_bank import ilv_pkg::*; #(
  parameter  int BANK_WORDS = 64,
  localparam int ROW_W      = $clog2(BANK_WORDS)
) (
  input  logic             clk,
  input  logic             en,
  input  logic             we,
  input  logic [BYTES-1:0] be,
  input  logic [ROW_W-1:0] row,
  input  word_t            wdata,
  output word_t            rdata
);
  word_t mem [BANK_WORDS];

  always_ff @(posedge clk) begin
    if (en) begin
      rdata <= mem[row];
      if (we) begin
        for (int i = 0; i < BYTES; i++) begin
          if (be[i]) mem[row][8*i +: 8] <= wdata[8*i +: 8];
        end
      end
    end
  end
endmodule

// File: rtl/ilv_xbar.sv
module ilv_xbar import ilv_pkg::*; #(
  parameter  int N_PORTS     = 4,
  parameter  int BANK_FACTOR = 2,
  parameter  int BANK_WORDS  = 64,
  localparam int N_BANKS     = N_PORTS * BANK_FACTOR,
  localparam int BANK_W      = $clog2(N_BANKS),
  localparam int ROW_W       = $clog2(BANK_WORDS),
  localparam int ADDR_W      = BANK_W + ROW_W,
  localparam int PORT_W      = $clog2(N_PORTS)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [N_PORTS-1:0]        req,
  input  logic [N_PORTS*ADDR_W-1:0] addr,
  input  logic [N_PORTS-1:0]        we,
  input  logic [N_PORTS*BYTES-1:0]  be,
  input  logic [N_PORTS*WORD_W-1:0] wdata,
  output logic [N_PORTS-1:0]        gnt,
  output logic [N_PORTS-1:0]        r_valid,
  output logic [N_PORTS*WORD_W-1:0] r_data
);
  // per-port unpacked views
  logic [BANK_W-1:0]  p_bank [N_PORTS];
  logic [ROW_W-1:0]   p_row  [N_PORTS];
  logic [BYTES-1:0]   p_be   [N_PORTS];
  word_t              p_wd   [N_PORTS];
  logic [N_BANKS-1:0] hit_pb [N_PORTS];

  // per-bank views
  logic [N_PORTS-1:0] gnt_bp  [N_BANKS];
  logic               b_valid [N_BANKS];
  logic [PORT_W-1:0]  b_win   [N_BANKS];
  word_t              b_rd    [N_BANKS];

  // response pipeline
  logic [N_PORTS-1:0] pend_v;
  logic [BANK_W-1:0]  pend_bank [N_PORTS];

  for (genvar p = 0; p < N_PORTS; p++) begin : g_port
    assign p_bank[p] = addr[p*ADDR_W +: BANK_W];
    assign p_row[p]  = addr[p*ADDR_W + BANK_W +: ROW_W];
    assign p_be[p]   = be[p*BYTES +: BYTES];
    assign p_wd[p]   = wdata[p*WORD_W +: WORD_W];

    ilv_route #(.N_BANKS(N_BANKS)) u_route (
      .req  (req[p]),
      .bank (p_bank[p]),
      .hit  (hit_pb[p])
    );
  end

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    logic [N_PORTS-1:0] breq;

    always_comb begin
      for (int p = 0; p < N_PORTS; p++) breq[p] = hit_pb[p][b];
    end

    ilv_arb_tree #(.N_PORTS(N_PORTS)) u_arb (
      .clk   (clk),
      .rst   (rst),
      .req   (breq),
      .gnt   (gnt_bp[b]),
      .valid (b_valid[b]),
      .win   (b_win[b])
    );

    ilv_bank #(.BANK_WORDS(BANK_WORDS)) u_mem (
      .clk   (clk),
      .en    (b_valid[b]),
      .we    (we[b_win[b]]),
      .be    (p_be[b_win[b]]),
      .row   (p_row[b_win[b]]),
      .wdata (p_wd[b_win[b]]),
      .rdata (b_rd[b])
    );
  end

  always_comb begin
    gnt = '0;
    for (int b = 0; b < N_BANKS; b++) gnt = gnt | gnt_bp[b];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_v  <= '0;
      r_valid <= '0;
    end else begin
      pend_v  <= gnt;
      r_valid <= pend_v;
    end
  end

  always_ff @(posedge clk) begin
    for (int p = 0; p < N_PORTS; p++) begin
      pend_bank[p] <= p_bank[p];
      if (pend_v[p]) r_data[p*WORD_W +: WORD_W] <= b_rd[pend_bank[p]];
    end
  end
endmodule

// File: rtl/ilv_xbar_chk.sv
module ilv_xbar_chk #(
  parameter  int N_PORTS     = 4,
  parameter  int BANK_FACTOR = 2,
  localparam int N_BANKS     = N_PORTS * BANK_FACTOR,
  localparam int BANK_W      = $clog2(N_BANKS)
) (
  input logic               clk,
  input logic               rst,
  input logic [N_PORTS-1:0] req,
  input logic [N_PORTS-1:0] gnt,
  input logic [N_PORTS-1:0] r_valid,
  input logic [BANK_W-1:0]  p_bank [N_PORTS]
);
  logic [N_PORTS-1:0] bk_req [N_BANKS];
  logic [N_PORTS-1:0] bk_gnt [N_BANKS];
  logic [N_PORTS-1:0] alone;
  logic [7:0]         stall_q [N_PORTS];

  always_comb begin
    for (int b = 0; b < N_BANKS; b++) begin
      for (int p = 0; p < N_PORTS; p++) begin
        bk_req[b][p] = req[p] && (p_bank[p] == BANK_W'(b));
        bk_gnt[b][p] = gnt[p] && (p_bank[p] == BANK_W'(b));
      end
    end
    for (int p = 0; p < N_PORTS; p++) begin
      alone[p] = req[p];
      for (int q = 0; q < N_PORTS; q++) begin
        if (q != p && req[q] && p_bank[q] == p_bank[p]) alone[p] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int p = 0; p < N_PORTS; p++) begin
      if (rst || !req[p] || gnt[p]) stall_q[p] <= '0;
      else if (stall_q[p] != 8'hFF) stall_q[p] <= stall_q[p] + 8'd1;
    end
  end

  assert_gnt_has_req_R2: assert property (@(posedge clk) disable iff (rst)
    (gnt & ~req) == '0);

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    assert_one_winner_R4: assert property (@(posedge clk) disable iff (rst)
      (|bk_req[b]) |-> ($countones(bk_gnt[b]) == 1));
  end

  for (genvar p = 0; p < N_PORTS; p++) begin : g_port
    assert_alone_granted_R3: assert property (@(posedge clk) disable iff (rst)
      alone[p] |-> gnt[p]);
    assert_rsp_has_gnt_R5: assert property (@(posedge clk) disable iff (rst)
      r_valid[p] |-> $past(gnt[p], 2));
    assert_gnt_gives_rsp_R5: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(rst, 2) && $past(gnt[p], 2)) |-> r_valid[p]);
    assert_stall_bounded_R7: assert property (@(posedge clk) disable iff (rst)
      stall_q[p] < 8'(N_PORTS));
  end
endmodule

bind ilv_xbar ilv_xbar_chk #(
  .N_PORTS     (N_PORTS),
  .BANK_FACTOR (BANK_FACTOR)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .req     (req),
  .gnt     (gnt),
  .r_valid (r_valid),
  .p_bank  (p_bank)
);

// File: tb/sim_ilv_xbar.sv
module sim_ilv_xbar;
  localparam int N   = 4;
  localparam int F   = 2;
  localparam int BWD = 64;
  localparam int M   = N * F;
  localparam int BKW = 3;
  localparam int RW  = 6;
  localparam int AW  = BKW + RW;
  localparam int TOT = M * BWD;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [N-1:0]    req = '0, we = '0;
  logic [N*AW-1:0] addr = '0;
  logic [N*4-1:0]  be = '0;
  logic [N*32-1:0] wdata = '0;
  logic [N-1:0]    gnt, r_valid;
  logic [N*32-1:0] r_data;

  ilv_xbar #(.N_PORTS(N), .BANK_FACTOR(F), .BANK_WORDS(BWD)) u0 (
    .clk(clk), .rst(rst), .req(req), .addr(addr), .we(we), .be(be),
    .wdata(wdata), .gnt(gnt), .r_valid(r_valid), .r_data(r_data)
  );

  int n_chk = 0;
  int n_err = 0;

  logic [31:0] mdl   [TOT];
  logic        known [TOT];

  logic          bv  [N];
  logic [AW-1:0] ba  [N];
  logic          bw  [N];
  logic [3:0]    bbe [N];
  logic [31:0]   bwd [N];

  logic [N-1:0] hv1 = '0, hv2 = '0, hk1 = '0, hk2 = '0;
  logic [31:0]  hd1 [N];
  logic [31:0]  hd2 [N];

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic set_req(input int p, input bit v, input logic [AW-1:0] a,
                         input bit w, input logic [3:0] e, input logic [31:0] d);
    bv[p] = v; ba[p] = a; bw[p] = w; bbe[p] = e; bwd[p] = d;
  endtask

  task automatic clear_reqs();
    for (int p = 0; p < N; p++) set_req(p, 1'b0, '0, 1'b0, 4'h0, '0);
  endtask

  function automatic logic [AW-1:0] wa(input int row, input int bank);
    return {RW'(row), BKW'(bank)};
  endfunction

  task automatic check_resp(input string rq);
    for (int p = 0; p < N; p++) begin
      chk(r_valid[p] === hv2[p], "R5", $sformatf("r_valid port %0d", p),
          32'(r_valid[p]), 32'(hv2[p]));
      if (hv2[p] && hk2[p])
        chk(r_data[p*32 +: 32] === hd2[p], rq,
            $sformatf("r_data port %0d", p), r_data[p*32 +: 32], hd2[p]);
    end
  endtask

  // Holds each request until granted; model updated in grant order.
  task automatic run_batch(input string rq);
    logic [N-1:0] pend;
    logic [N-1:0] nv;
    logic [N-1:0] nk;
    logic [31:0]  nd [N];
    for (int p = 0; p < N; p++) pend[p] = bv[p];
    for (int cyc = 0; cyc < 64; cyc++) begin
      @(negedge clk);
      check_resp(rq);
      for (int p = 0; p < N; p++) begin
        req[p] = pend[p];
        addr[p*AW +: AW] = ba[p];
        we[p] = bw[p];
        be[p*4 +: 4] = bbe[p];
        wdata[p*32 +: 32] = bwd[p];
      end
      #2;
      chk((gnt & ~pend) == '0, "R2", "grant without request", 32'(gnt), 32'(pend));
      for (int b = 0; b < M; b++) begin
        int nr = 0;
        int ng = 0;
        for (int p = 0; p < N; p++) begin
          if (pend[p] && ba[p][BKW-1:0] == BKW'(b)) nr++;
          if (gnt[p] && ba[p][BKW-1:0] == BKW'(b)) ng++;
        end
        if (nr == 1) chk(ng == 1, "R1 R2 R3", $sformatf("lone request bank %0d", b), ng, 1);
        else if (nr > 1) chk(ng == 1, "R1 R4", $sformatf("winners bank %0d", b), ng, 1);
      end
      nv = gnt & pend;
      nk = '0;
      for (int p = 0; p < N; p++) begin
        nd[p] = '0;
        if (nv[p]) begin
          int ix = int'(ba[p]);
          nd[p] = mdl[ix];
          nk[p] = known[ix];
          if (bw[p]) begin
            for (int i = 0; i < 4; i++)
              if (bbe[p][i]) mdl[ix][8*i +: 8] = bwd[p][8*i +: 8];
            known[ix] = known[ix] || (bbe[p] == 4'hF);
          end
        end
      end
      hv2 = hv1; hk2 = hk1; hd2 = hd1;
      hv1 = nv;  hk1 = nk;  hd1 = nd;
      pend = pend & ~gnt;
      if (pend == '0 && hv1 == '0 && hv2 == '0) break;
    end
    chk(pend == '0, "R8", "requests left unserved", 32'(pend), 32'h0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(gnt === '0, "R10", "gnt in reset", 32'(gnt), 0);
    chk(r_valid === '0, "R10", "r_valid in reset", 32'(r_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(r_valid === '0, "R10", "r_valid after reset", 32'(r_valid), 0);
    chk(gnt === '0, "R10", "gnt idle", 32'(gnt), 0);
  endtask

  task automatic t_parallel();
    clear_reqs();
    for (int p = 0; p < N; p++) set_req(p, 1, wa(2, p), 1, 4'hF, 32'hC0DE_0000 + p);
    run_batch("R3 R9");
    for (int p = 0; p < N; p++) set_req(p, 1, wa(2, (p + 1) % N), 0, 4'h0, '0);
    run_batch("R1 R3 R6");
    for (int p = 0; p < N; p++) set_req(p, 1, wa(5 + p, 4 + p), 1, 4'hF, 32'h5A5A_0F00 ^ (p * 32'h1111));
    run_batch("R3 R9");
    for (int p = 0; p < N; p++) set_req(p, 1, wa(5 + p, 4 + p), 0, 4'h0, '0);
    run_batch("R3 R6");
  endtask

  task automatic t_byte_lanes();
    clear_reqs();
    set_req(2, 1, wa(1, 1), 1, 4'hF, 32'h1122_3344);
    run_batch("R6 R9");
    set_req(2, 1, wa(1, 1), 1, 4'b0101, 32'hAABB_CCDD);
    run_batch("R6 R9");
    clear_reqs();
    set_req(0, 1, wa(1, 1), 0, 4'h0, '0);
    run_batch("R6");
    chk(mdl[int'(wa(1, 1))] == 32'h11BB_33DD, "R6", "lane model", mdl[int'(wa(1, 1))], 32'h11BB_33DD);
  endtask

  task automatic t_conflict();
    clear_reqs();
    set_req(0, 1, wa(10, 3), 1, 4'hF, 32'hA000_0001);
    set_req(1, 1, wa(11, 3), 1, 4'hF, 32'hA000_0002);
    set_req(2, 1, wa(10, 4), 1, 4'hF, 32'hA000_0003);
    set_req(3, 1, wa(12, 3), 1, 4'hF, 32'hA000_0004);
    run_batch("R4 R8 R9");
    set_req(0, 1, wa(12, 3), 0, 4'h0, '0);
    set_req(1, 1, wa(10, 3), 0, 4'h0, '0);
    set_req(2, 1, wa(10, 4), 0, 4'h0, '0);
    set_req(3, 1, wa(11, 3), 0, 4'h0, '0);
    run_batch("R1 R4 R8");
  endtask

  task automatic t_rw_same();
    clear_reqs();
    set_req(0, 1, wa(20, 6), 1, 4'hF, 32'h0BAD_F00D);
    run_batch("R9");
    set_req(0, 1, wa(20, 6), 1, 4'hF, 32'h600D_CAFE);
    set_req(1, 1, wa(20, 6), 0, 4'h0, '0);
    set_req(2, 1, wa(21, 6), 0, 4'h0, '0);
    run_batch("R8 R9");
    clear_reqs();
    set_req(3, 1, wa(20, 6), 0, 4'h0, '0);
    run_batch("R8");
  endtask

  task automatic t_fair();
    int cnt   [N];
    int stall [N];
    int worst;
    worst = 0;
    for (int p = 0; p < N; p++) begin cnt[p] = 0; stall[p] = 0; end
    for (int cyc = 0; cyc < 2 * N; cyc++) begin
      @(negedge clk);
      for (int p = 0; p < N; p++) begin
        req[p] = 1'b1;
        we[p] = 1'b0;
        addr[p*AW +: AW] = wa(30 + p, 5);
      end
      #2;
      chk($countones(gnt) == 1, "R4 R7", "grants per cycle", $countones(gnt), 1);
      for (int p = 0; p < N; p++) begin
        if (gnt[p]) begin cnt[p]++; stall[p] = 0; end
        else begin stall[p]++; if (stall[p] > worst) worst = stall[p]; end
      end
    end
    @(negedge clk);
    req = '0;
    for (int p = 0; p < N; p++)
      chk(cnt[p] == 2, "R7", $sformatf("grants port %0d", p), cnt[p], 2);
    chk(worst < N, "R7", "longest stall", worst, N - 1);
    repeat (3) @(negedge clk);
    chk(r_valid === '0, "R5", "r_valid after drain", 32'(r_valid), 0);
    hv1 = '0; hv2 = '0;
  endtask

  initial begin
    for (int i = 0; i < TOT; i++) known[i] = 1'b0;
    for (int p = 0; p < N; p++) begin hd1[p] = '0; hd2[p] = '0; end
    clear_reqs();
    t_reset();
    t_parallel();
    t_byte_lanes();
    t_conflict();
    t_rw_same();
    t_fair();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(20 * 50000);
    n_err++;
    $display("FAIL R8 watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule